// File: doc/BRIEF.md
# Dual-channel DMA control and interrupt register bank

This block is the register face of a two-direction DMA engine. One channel moves data from memory out to a stream (the outbound channel); the other takes a stream in and writes it to memory (the inbound channel). A host reaches the block over a simple 32-bit register bus with separate write and read strobes. The block stores each channel's setup values and turns a rising start bit into a one-cycle launch pulse toward the datapath. It collects the datapath's completion and error strobes into a status word per channel.

Two interrupt conditions exist per channel, error and completion. Each is gated by its own enable bit and recorded in a sticky flag. The host clears a flag by writing 1 to it. A single level-sensitive interrupt line is high while any flag is set. For the inbound channel the block also counts the bytes of every accepted stream beat from launch through the beat that carries the end-of-packet marker, and freezes that total for the host to read.

The memory-side masters, address generation and data movement are outside this block. They appear here only as launch pulses going out and done, error and beat strobes coming in.

Top module: `dma_ctrl_regs`

## Requirements
- R1: A write to a channel control register (outbound 0x00, inbound 0x20) launches that channel only when bit 0 goes from 0 in the stored value to 1 in the written value. The launch raises that channel's start output for exactly one cycle, the cycle after the write. Writing 1 while bit 0 already holds 1 does not launch.
- R2: Configuration registers read back what was written through a fixed mask. The outbound control mask is 0x00FFFF3D and the inbound control mask is 0x00000031. Base addresses at 0x08 and 0x28 keep all 32 bits, and so do the dimension registers at 0x0C and 0x10. The row register at 0x14 keeps bits 19:0.
- R3: Each status register (outbound 0x04, inbound 0x24) reads {26'b0, done-flag[5], error-flag[4], error-code[3:1], done[0]}. A completion strobe while busy sets done and ends busy. An accepted launch clears done and the error code.
- R4: A flag is set only when its event happens while the matching enable holds 1 in the stored control value: bit 4 for the error flag, bit 5 for the done flag.
- R5: Writing a status register clears each flag whose bit in the written data is 1 and leaves the other flags unchanged. The done bit and the error code are not writable.
- R6: The irq output is high whenever any of the four flags is set, and low otherwise.
- R7: A launch request made while the channel is busy produces no start pulse. It sets that channel's error code to 3'b001 and raises the error flag if the error interrupt is enabled.
- R8: An error strobe while busy latches the 3-bit code supplied with it into the error code and ends busy.
- R9: Done and error strobes that arrive while a channel is idle change nothing.
- R10: From each inbound launch, the block sums the byte counts of the accepted beats up to and including the beat flagged last. It latches that sum into the read-only length register at 0x2C. Beats after that last beat, or while the channel is idle, are not counted, and writes to 0x2C have no effect.
- R11: Reads of unmapped offsets return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high, 0 otherwise |
| out_start | output | 1 | One-cycle launch pulse for the outbound channel |
| out_done | input | 1 | Outbound completion strobe |
| out_err | input | 1 | Outbound error strobe |
| out_err_code | input | 3 | Error code qualified by out_err |
| in_start | output | 1 | One-cycle launch pulse for the inbound channel |
| in_done | input | 1 | Inbound completion strobe |
| in_err | input | 1 | Inbound error strobe |
| in_err_code | input | 3 | Error code qualified by in_err |
| in_beat | input | 1 | An inbound stream beat is accepted this cycle |
| in_beat_bytes | input | BYTES_W | Number of valid bytes in that beat |
| in_beat_last | input | 1 | That beat carries the end-of-packet marker |
| irq | output | 1 | Level interrupt, OR of all flags |

## Verification
Register reads are combinational, so read data is due in the same cycle as reg_rd. Writes and datapath strobes take effect at the clock edge that samples them, which makes status, flags and irq visible in the following cycle. A start pulse is high during the single cycle after the launching write. The bench drives every input one time unit after a rising edge and samples at the falling edge, so each result is read in the middle of the cycle in which it is due. Read expectations go through a scoreboard queue, and start pulses are counted at falling edges and compared after one full cycle has passed.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // register offsets; inbound channel sits one stride above outbound
  localparam int CH_STRIDE    = 'h20;
  localparam int OFF_CTRL     = 'h00;
  localparam int OFF_STAT     = 'h04;
  localparam int OFF_BASE     = 'h08;
  localparam int OFF_OUT_DIM1 = 'h0C;
  localparam int OFF_OUT_DIM2 = 'h10;
  localparam int OFF_OUT_ROW  = 'h14;
  localparam int OFF_IN_LEN   = 'h2C;

  // control bit positions
  localparam int BIT_GO      = 0;
  localparam int BIT_ERR_EN  = 4;
  localparam int BIT_DONE_EN = 5;

  localparam logic [31:0] OUT_CTRL_MASK = 32'h00FF_FF3D;
  localparam logic [31:0] IN_CTRL_MASK  = 32'h0000_0031;
  localparam logic [31:0] ROW_MASK      = 32'h000F_FFFF;

  localparam logic [2:0] ERR_BUSY_LAUNCH = 3'b001;

  typedef struct packed {
    logic       fdone;
    logic       ferr;
    logic [2:0] code;
    logic       done;
  } chan_stat_t;

  function automatic logic go_edge(input logic old_b, input logic new_b);
    return new_b & ~old_b;
  endfunction

  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [31:0] len_step(input logic [31:0] acc, input logic [31:0] add);
    return acc + add;
  endfunction

  function automatic int ctrl_off(input int ch);
    return ch * CH_STRIDE + OFF_CTRL;
  endfunction

  function automatic int stat_off(input int ch);
    return ch * CH_STRIDE + OFF_STAT;
  endfunction

endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_regs_pkg::*;
#(
  parameter logic [31:0] CTRL_MASK = OUT_CTRL_MASK
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        stat_we,
  input  logic [31:0] wdata,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [2:0]  err_code_i,
  output logic [31:0] ctrl_o,
  output chan_stat_t  stat_o,
  output logic        start_o,
  output logic        busy_o,
  output logic        launch_ok_o,
  output logic        launch_rej_o
);

  logic [31:0] ctrl_q;
  logic        busy_q;
  logic        start_q;
  chan_stat_t  stat_q;

  logic launch_req, launch_ok, launch_rej;
  logic fin_done, fin_err;
  logic set_ferr, set_fdone;
  logic clr_ferr, clr_fdone;

  assign launch_req = ctrl_we && go_edge(ctrl_q[BIT_GO], wdata[BIT_GO]);
  assign launch_ok  = launch_req && !busy_q;
  assign launch_rej = launch_req && busy_q;
  assign fin_done   = done_i && busy_q;
  assign fin_err    = err_i && busy_q;

  assign set_ferr  = (fin_err || launch_rej) && ctrl_q[BIT_ERR_EN];
  assign set_fdone = fin_done && ctrl_q[BIT_DONE_EN];
  assign clr_ferr  = stat_we && wdata[4];
  assign clr_fdone = stat_we && wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata & CTRL_MASK;
      start_q <= launch_ok;

      if (launch_ok)                busy_q <= 1'b1;
      else if (fin_done || fin_err) busy_q <= 1'b0;

      if (launch_ok)     stat_q.done <= 1'b0;
      else if (fin_done) stat_q.done <= 1'b1;

      if (launch_ok)       stat_q.code <= 3'b000;
      else if (fin_err)    stat_q.code <= err_code_i;
      else if (launch_rej) stat_q.code <= ERR_BUSY_LAUNCH;

      stat_q.ferr  <= sticky_next(stat_q.ferr, set_ferr, clr_ferr);
      stat_q.fdone <= sticky_next(stat_q.fdone, set_fdone, clr_fdone);
    end
  end

  assign ctrl_o       = ctrl_q;
  assign stat_o       = stat_q;
  assign start_o      = start_q;
  assign busy_o       = busy_q;
  assign launch_ok_o  = launch_ok;
  assign launch_rej_o = launch_rej;

endmodule

// File: rtl/dma_rx_len.sv
module dma_rx_len
  import dma_regs_pkg::*;
#(
  parameter int BYTES_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               run,
  input  logic               beat,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic               beat_last,
  output logic               last_fire_o,
  output logic [31:0]        len_o
);

  logic [31:0] acc_q;
  logic [31:0] len_q;
  logic        cap_q;
  logic        take;
  logic [31:0] sum;

  assign take        = beat && run && !cap_q;
  assign last_fire_o = take && beat_last;
  assign sum         = len_step(acc_q, 32'(beat_bytes));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      len_q <= '0;
      cap_q <= 1'b0;
    end else begin
      if (launch) begin
        acc_q <= '0;
        cap_q <= 1'b0;
      end else if (take) begin
        acc_q <= sum;
        if (beat_last) cap_q <= 1'b1;
      end
      if (last_fire_o) len_q <= sum;
    end
  end

  assign len_o = len_q;

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BYTES_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               out_start,
  input  logic               out_done,
  input  logic               out_err,
  input  logic [2:0]         out_err_code,
  output logic               in_start,
  input  logic               in_done,
  input  logic               in_err,
  input  logic [2:0]         in_err_code,
  input  logic               in_beat,
  input  logic [BYTES_W-1:0] in_beat_bytes,
  input  logic               in_beat_last,
  output logic               irq
);

  localparam int NCH = 2;

  logic [NCH-1:0] done_v, err_v, ctrl_we_v, stat_we_v;
  logic [NCH-1:0] start_v, busy_v, launch_ok_v, launch_rej_v;
  logic [NCH-1:0] flag_err_v, flag_done_v, en_err_v, en_done_v;
  logic [2:0]     code_v [NCH];
  logic [31:0]    ctrl_v [NCH];
  chan_stat_t     stat_v [NCH];

  logic [31:0] out_base_q, out_dim1_q, out_dim2_q, out_row_q, in_base_q;
  logic [31:0] rx_len;
  logic        rx_last_fire;

  assign done_v    = {in_done, out_done};
  assign err_v     = {in_err, out_err};
  assign code_v[0] = out_err_code;
  assign code_v[1] = in_err_code;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [31:0] MASK = (c == 0) ? OUT_CTRL_MASK : IN_CTRL_MASK;

    assign ctrl_we_v[c] = reg_wr && hit(reg_addr, ctrl_off(c));
    assign stat_we_v[c] = reg_wr && hit(reg_addr, stat_off(c));

    dma_chan_ctl #(.CTRL_MASK(MASK)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_we      (ctrl_we_v[c]),
      .stat_we      (stat_we_v[c]),
      .wdata        (reg_wdata),
      .done_i       (done_v[c]),
      .err_i        (err_v[c]),
      .err_code_i   (code_v[c]),
      .ctrl_o       (ctrl_v[c]),
      .stat_o       (stat_v[c]),
      .start_o      (start_v[c]),
      .busy_o       (busy_v[c]),
      .launch_ok_o  (launch_ok_v[c]),
      .launch_rej_o (launch_rej_v[c])
    );

    assign flag_err_v[c]  = stat_v[c].ferr;
    assign flag_done_v[c] = stat_v[c].fdone;
    assign en_err_v[c]    = ctrl_v[c][BIT_ERR_EN];
    assign en_done_v[c]   = ctrl_v[c][BIT_DONE_EN];
  end

  dma_rx_len #(.BYTES_W(BYTES_W)) u_rx_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch_ok_v[1]),
    .run         (busy_v[1]),
    .beat        (in_beat),
    .beat_bytes  (in_beat_bytes),
    .beat_last   (in_beat_last),
    .last_fire_o (rx_last_fire),
    .len_o       (rx_len)
  );

  // plain configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_base_q <= '0;
      out_dim1_q <= '0;
      out_dim2_q <= '0;
      out_row_q  <= '0;
      in_base_q  <= '0;
    end else if (reg_wr) begin
      if (hit(reg_addr, OFF_BASE))             out_base_q <= reg_wdata;
      if (hit(reg_addr, OFF_OUT_DIM1))         out_dim1_q <= reg_wdata;
      if (hit(reg_addr, OFF_OUT_DIM2))         out_dim2_q <= reg_wdata;
      if (hit(reg_addr, OFF_OUT_ROW))          out_row_q  <= reg_wdata & ROW_MASK;
      if (hit(reg_addr, CH_STRIDE + OFF_BASE)) in_base_q  <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if      (hit(reg_addr, ctrl_off(0)))          reg_rdata = ctrl_v[0];
      else if (hit(reg_addr, stat_off(0)))          reg_rdata = {26'b0, stat_v[0]};
      else if (hit(reg_addr, OFF_BASE))             reg_rdata = out_base_q;
      else if (hit(reg_addr, OFF_OUT_DIM1))         reg_rdata = out_dim1_q;
      else if (hit(reg_addr, OFF_OUT_DIM2))         reg_rdata = out_dim2_q;
      else if (hit(reg_addr, OFF_OUT_ROW))          reg_rdata = out_row_q;
      else if (hit(reg_addr, ctrl_off(1)))          reg_rdata = ctrl_v[1];
      else if (hit(reg_addr, stat_off(1)))          reg_rdata = {26'b0, stat_v[1]};
      else if (hit(reg_addr, CH_STRIDE + OFF_BASE)) reg_rdata = in_base_q;
      else if (hit(reg_addr, OFF_IN_LEN))           reg_rdata = rx_len;
    end
  end

  assign out_start = start_v[0];
  assign in_start  = start_v[1];
  assign irq       = |{flag_err_v, flag_done_v};

endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        start_v,
  input logic [1:0]        launch_rej_v,
  input logic [1:0]        flag_err_v,
  input logic [1:0]        flag_done_v,
  input logic [1:0]        en_err_v,
  input logic [1:0]        en_done_v,
  input logic              rx_last_fire,
  input logic [31:0]       rx_len
);

  // R1: a pulse always follows a write of 1 to that channel's control bit 0
  a_r1_out_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    start_v[0] |-> $past(reg_wr && reg_addr == ADDR_W'('h00) && reg_wdata[0]));
  a_r1_in_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    start_v[1] |-> $past(reg_wr && reg_addr == ADDR_W'('h20) && reg_wdata[0]));

  // R1: pulses last a single cycle
  a_r1_out_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_v[0] |=> !start_v[0]);
  a_r1_in_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_v[1] |=> !start_v[1]);

  // R7: a rejected launch yields no pulse
  a_r7_out_reject: assert property (@(posedge clk) disable iff (!rst_n)
    launch_rej_v[0] |=> !start_v[0]);
  a_r7_in_reject: assert property (@(posedge clk) disable iff (!rst_n)
    launch_rej_v[1] |=> !start_v[1]);

  // R4: flags rise only with their enable set
  a_r4_out_done_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done_v[0]) |-> $past(en_done_v[0]));
  a_r4_out_err_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err_v[0]) |-> $past(en_err_v[0]));
  a_r4_in_done_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done_v[1]) |-> $past(en_done_v[1]));
  a_r4_in_err_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err_v[1]) |-> $past(en_err_v[1]));

  // R10: the length register only moves on the last beat
  a_r10_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_last_fire |=> $stable(rx_len));

endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .start_v      (start_v),
  .launch_rej_v (launch_rej_v),
  .flag_err_v   (flag_err_v),
  .flag_done_v  (flag_done_v),
  .en_err_v     (en_err_v),
  .en_done_v    (en_done_v),
  .rx_last_fire (rx_last_fire),
  .rx_len       (rx_len)
);

// File: tb/dma_ctrl_regs_test.sv
module dma_ctrl_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BYTES_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic out_start, in_start, irq;
  logic out_done = 1'b0, out_err = 1'b0, in_done = 1'b0, in_err = 1'b0;
  logic [2:0] out_err_code = '0, in_err_code = '0;
  logic in_beat = 1'b0, in_beat_last = 1'b0;
  logic [BYTES_W-1:0] in_beat_bytes = '0;

  int checks = 0;
  int errors = 0;
  int out_pulses = 0;
  int in_pulses = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctrl_regs #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_start(out_start), .out_done(out_done), .out_err(out_err),
    .out_err_code(out_err_code), .in_start(in_start), .in_done(in_done),
    .in_err(in_err), .in_err_code(in_err_code), .in_beat(in_beat),
    .in_beat_bytes(in_beat_bytes), .in_beat_last(in_beat_last), .irq(irq)
  );

  // monitor: pop expected read data and count start pulses at falling edges
  always @(negedge clk) begin
    if (out_start) out_pulses++;
    if (in_start) in_pulses++;
    if (reg_rd) begin
      sb_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: got %h expected none", reg_rdata);
      end else begin
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    @(posedge clk); #1;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic beat(input int n, input logic last);
    @(posedge clk); #1;
    in_beat = 1'b1; in_beat_bytes = BYTES_W'(n); in_beat_last = last;
    @(posedge clk); #1;
    in_beat = 1'b0; in_beat_last = 1'b0;
  endtask

  task automatic strobe_out_done();
    @(posedge clk); #1; out_done = 1'b1;
    @(posedge clk); #1; out_done = 1'b0;
  endtask

  task automatic strobe_in_done();
    @(posedge clk); #1; in_done = 1'b1;
    @(posedge clk); #1; in_done = 1'b0;
  endtask

  task automatic strobe_in_err(input logic [2:0] code);
    @(posedge clk); #1; in_err = 1'b1; in_err_code = code;
    @(posedge clk); #1; in_err = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd('h04, 32'h0, "R3 reset outbound status");
    rd('h24, 32'h0, "R3 reset inbound status");
    rd('h2C, 32'h0, "R10 reset length");
    check(irq, 1'b0, "R6 reset irq");

    // outbound launch with both enables
    wr('h00, 32'h31);
    settle();
    check(out_pulses, 1, "R1 outbound launch pulse");
    rd('h00, 32'h31, "R2 outbound control readback");
    rd('h04, 32'h0, "R3 busy status");

    // rewrite of 1 does not relaunch
    wr('h00, 32'h31);
    settle();
    check(out_pulses, 1, "R1 level write no relaunch");
    rd('h04, 32'h0, "R1 no error from level write");

    // edge while busy is rejected
    wr('h00, 32'h30);
    wr('h00, 32'h31);
    settle();
    check(out_pulses, 1, "R7 busy launch no pulse");
    rd('h04, 32'h12, "R7 busy launch error code and flag");
    check(irq, 1'b1, "R6 irq from error flag");

    // completion
    strobe_out_done();
    rd('h04, 32'h33, "R3 done bit and done flag");

    // write one to clear
    wr('h04, 32'h10);
    rd('h04, 32'h23, "R5 clear error flag only");
    check(irq, 1'b1, "R6 irq held by done flag");
    wr('h04, 32'h20);
    rd('h04, 32'h03, "R5 clear done flag");
    check(irq, 1'b0, "R6 irq low with no flags");

    // unmapped
    wr('h18, 32'hFFFF_FFFF);
    rd('h18, 32'h0, "R11 unmapped read zero");
    rd('h3C, 32'h0, "R11 high unmapped read zero");
    rd('h04, 32'h03, "R11 unmapped write no effect");

    // inbound: error enable only
    wr('h20, 32'hFFFF_FFF1);
    settle();
    check(in_pulses, 1, "R1 inbound launch pulse");
    rd('h20, 32'h31, "R2 inbound control mask");
    wr('h20, 32'h11);
    beat(4, 1'b0);
    beat(4, 1'b0);
    beat(3, 1'b1);
    rd('h2C, 32'd11, "R10 length through last beat");
    beat(4, 1'b0);
    rd('h2C, 32'd11, "R10 beat after last ignored");
    strobe_in_done();
    rd('h24, 32'h01, "R4 done without enable sets no flag");
    check(irq, 1'b0, "R4 irq stays low");

    // relaunch clears status; error strobe latches code
    wr('h20, 32'h10);
    wr('h20, 32'h11);
    settle();
    check(in_pulses, 2, "R1 inbound relaunch");
    rd('h24, 32'h00, "R3 launch clears done and code");
    strobe_in_err(3'd5);
    rd('h24, 32'h1A, "R8 error code latched with flag");
    check(irq, 1'b1, "R6 irq from inbound error");
    beat(7, 1'b1);
    rd('h2C, 32'd11, "R10 beat while idle ignored");
    wr('h2C, 32'h0);
    rd('h2C, 32'd11, "R10 length read only");

    // strobes while idle
    strobe_out_done();
    rd('h04, 32'h03, "R9 idle done strobe ignored");
    strobe_in_err(3'd7);
    rd('h24, 32'h1A, "R9 idle error strobe ignored");

    // configuration storage
    wr('h08, 32'hDEAD_BEEF);
    rd('h08, 32'hDEAD_BEEF, "R2 outbound base");
    wr('h28, 32'h1234_5678);
    rd('h28, 32'h1234_5678, "R2 inbound base");
    wr('h0C, 32'hA5A5_5A5A);
    rd('h0C, 32'hA5A5_5A5A, "R2 dimension one");
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, 32'hFFFF_FFFF, "R2 dimension two");
    wr('h14, 32'hFFFF_FFFF);
    rd('h14, 32'h000F_FFFF, "R2 row mask");
    wr('h00, 32'hFFFF_FFFE);
    rd('h00, 32'h00FF_FF3C, "R2 outbound control mask");

    settle();
    report();
    $finish;
  end

endmodule